// File: doc/BRIEF.md
# Single-Wire Bus Link Monitor

This block listens passively to one open-drain, single-wire serial line and turns the low pulses it sees into link-level events. It runs on a system clock that oversamples the line. Each low pulse is classified as either a data time slot or a reset pulse. For a data slot the block samples the bit value at a fixed offset after the falling edge. After a reset it samples the line at a presence offset to learn whether a device answered. Every classified slot comes out as a one-cycle event carrying the event kind, the bit, the presence flag and the current speed mode. The block never drives the line.

Two speeds are supported: standard and overdrive. Each has its own slot length, sample offset, reset threshold, presence offset and recovery length, and all of these are parameters counted in clock cycles. After a standard-length reset the block collects the first eight data bits, least significant bit first, into a command byte. If that byte is one of the two overdrive commands (0x3C or 0x69), the block switches itself to overdrive timing, starting with the next slot.

The control is a five-state machine, with states named here after what they are waiting for:

- IDLE waits for the line to go low. A low line moves to SLOT and starts the elapsed counter.
- SLOT latches the bit at the sample offset. At the slot count, a high line emits a bit event and returns to IDLE; a low line moves to RISE.
- RISE waits for a high line. A long low goes to PRES as a reset and restarts the counter. A shorter low returns to IDLE with no event.
- PRES latches the presence level at the presence offset and moves to RECOV.
- RECOV checks the line at the recovery count. A high line emits the reset event and returns to IDLE. A low line goes back to RISE, and that low is then always treated as a standard reset.

Top module: `single_wire_monitor`

## Requirements
- R1: After reset the block emits no event, and its overdrive state is off: the first event after reset reports overdrive 0.
- R2: A data bit is the synchronized line level at the sample offset after the fall. The offset is STD_SAMPLE cycles at standard speed and OD_SAMPLE cycles in overdrive.
- R3: If the line is high at the slot count after the fall, the block emits exactly one event with kind 0 (bit) and the sampled bit value.
- R4: If the line is still low at the slot count, and the low time is at most the active reset threshold when the line rises, no event is emitted. The block then returns to waiting for a falling edge.
- R5: A low time longer than STD_RESET is a reset. It forces overdrive off and clears the command bit count and the command byte.
- R6: While in overdrive, a low time longer than OD_RESET but not longer than STD_RESET is also a reset, and overdrive stays on.
- R7: The presence flag of a reset event is the inverse of the line level sampled at the presence offset after the rising edge (low means a device is present).
- R8: If the line is high at the recovery count after the rising edge, the block emits one event with kind 1 (reset). If the line is low there, the block waits for the line to rise again and treats that rise as a standard reset.
- R9: The first eight bits after a standard reset form a command byte, least significant bit first. A byte of 0x3C or 0x69 turns overdrive on. The eighth bit's event still reports overdrive 0, and the following slots use overdrive timing and report overdrive 1. Other byte values, and bits after the eighth, leave the speed unchanged.
- R10: Each event is a single-cycle pulse on ev_valid_o; ev_valid_o is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the line |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_i | input | 1 | Bus line level, asynchronous |
| ev_valid_o | output | 1 | One-cycle event strobe |
| ev_kind_o | output | 1 | Event kind: 0 bit, 1 reset/presence |
| ev_bit_o | output | 1 | Sampled bit value for bit events, 0 otherwise |
| ev_present_o | output | 1 | Presence flag for reset events, 0 otherwise |
| ev_od_o | output | 1 | Overdrive state at the time of the event |

## Verification
The hardest case to reach from the ports is a line held low across the recovery count after a reset. That case sends the machine back to RISE with no intervening fall, so the following rise must still count as a reset. The stimulus reaches it by holding a presence-style low well past the recovery count, then releasing the line and expecting exactly one reset event with the presence level sampled on the second pass. A second hard case is the speed change itself. The bench keeps its own command-byte model, so the expected overdrive flag flips exactly after the eighth bit, and the following bits are driven with overdrive pulse widths that only decode correctly if the timing switched.

// File: rtl/swm_pkg.sv
package swm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_SLOT  = 3'd1,
        ST_RISE  = 3'd2,
        ST_PRES  = 3'd3,
        ST_RECOV = 3'd4
    } swm_state_e;

    typedef enum logic {
        EV_BIT   = 1'b0,
        EV_RESET = 1'b1
    } swm_kind_e;

endpackage

// File: rtl/swm_sync.sv
module swm_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] sr_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sr_q <= '1;
                else        sr_q <= async_i;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sr_q <= '1;
                else        sr_q <= {sr_q[STAGES-2:0], async_i};
            end
        end
    endgenerate

    assign sync_o = sr_q[STAGES-1];
endmodule

// File: rtl/swm_timer.sv
module swm_timer #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/swm_cmd_track.sv
module swm_cmd_track #(
    parameter int          CMD_W     = 8,
    parameter logic [7:0]  OD_CODE_A = 8'h3C,
    parameter logic [7:0]  OD_CODE_B = 8'h69
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic bit_stb_i,
    input  logic bit_i,
    output logic od_o
);
    localparam int PTR_W = $clog2(CMD_W);
    localparam int IDX_W = $clog2(CMD_W + 1);
    localparam logic [IDX_W-1:0] IDX_FULL = IDX_W'(CMD_W);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(CMD_W - 1);

    logic [CMD_W-1:0] cmd_q;
    logic [CMD_W-1:0] cmd_next;
    logic [IDX_W-1:0] cnt_q;
    logic             od_q;
    logic             code_hit;

    always_comb begin
        cmd_next = cmd_q;
        if (cnt_q < IDX_FULL) begin
            cmd_next[cnt_q[PTR_W-1:0]] = bit_i;
        end
        code_hit = (cmd_next == CMD_W'(OD_CODE_A)) || (cmd_next == CMD_W'(OD_CODE_B));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q <= '0;
            cnt_q <= '0;
            od_q  <= 1'b0;
        end else if (clr_i) begin
            cmd_q <= '0;
            cnt_q <= '0;
            od_q  <= 1'b0;
        end else if (bit_stb_i && (cnt_q < IDX_FULL)) begin
            cmd_q <= cmd_next;
            cnt_q <= cnt_q + 1'b1;
            if ((cnt_q == IDX_LAST) && code_hit) begin
                od_q <= 1'b1;
            end
        end
    end

    assign od_o = od_q;

    AST_OD_AFTER_FULL_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(od_q) |-> (cnt_q == IDX_FULL)); // R9
    AST_CMD_COUNT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= IDX_FULL); // R9
    AST_CLEAR_DROPS_OD: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (!od_q && cnt_q == '0)); // R5
endmodule

// File: rtl/single_wire_monitor.sv
module single_wire_monitor #(
    parameter int CNT_W      = 12,
    parameter int SYNC_STAGES = 2,
    parameter int STD_SLOT   = 60,
    parameter int STD_SAMPLE = 15,
    parameter int STD_RESET  = 480,
    parameter int STD_PRES   = 70,
    parameter int STD_RECOV  = 410,
    parameter int OD_SLOT    = 8,
    parameter int OD_SAMPLE  = 2,
    parameter int OD_RESET   = 48,
    parameter int OD_PRES    = 8,
    parameter int OD_RECOV   = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic ev_valid_o,
    output logic ev_kind_o,
    output logic ev_bit_o,
    output logic ev_present_o,
    output logic ev_od_o
);
    import swm_pkg::*;

    localparam logic [CNT_W-1:0] ONE_C      = CNT_W'(1);
    localparam logic [CNT_W-1:0] STD_RST_C  = CNT_W'(STD_RESET);
    localparam logic [CNT_W-1:0] OD_RST_C   = CNT_W'(OD_RESET);
    localparam logic [CNT_W-1:0] LONG_MARK  = CNT_W'(STD_RESET + 1);

    swm_state_e       st_q, st_d;
    logic             line_s;
    logic [CNT_W-1:0] t_cnt;
    logic             t_load;
    logic [CNT_W-1:0] t_val;
    logic             od;
    logic             emit_bit, emit_rst, rst_std, take_sample, take_pres;
    logic             bit_q, pres_q;
    logic [CNT_W-1:0] slot_c, sample_c, pres_c, recov_c;

    swm_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (line_i),
        .sync_o  (line_s)
    );

    swm_timer #(.CNT_W(CNT_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (t_load),
        .load_val_i (t_val),
        .cnt_o      (t_cnt)
    );

    swm_cmd_track u_cmd (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (rst_std),
        .bit_stb_i (emit_bit),
        .bit_i     (bit_q),
        .od_o      (od)
    );

    // Speed-dependent counts
    assign slot_c   = od ? CNT_W'(OD_SLOT)   : CNT_W'(STD_SLOT);
    assign sample_c = od ? CNT_W'(OD_SAMPLE) : CNT_W'(STD_SAMPLE);
    assign pres_c   = od ? CNT_W'(OD_PRES)   : CNT_W'(STD_PRES);
    assign recov_c  = od ? CNT_W'(OD_RECOV)  : CNT_W'(STD_RECOV);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Transitions and strobes
    always_comb begin
        st_d        = st_q;
        t_load      = 1'b0;
        t_val       = '0;
        emit_bit    = 1'b0;
        emit_rst    = 1'b0;
        rst_std     = 1'b0;
        take_sample = 1'b0;
        take_pres   = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (!line_s) begin
                    st_d   = ST_SLOT;
                    t_load = 1'b1;
                    t_val  = ONE_C;
                end
            end
            ST_SLOT: begin
                if (t_cnt == sample_c) take_sample = 1'b1;
                if (t_cnt == slot_c) begin
                    if (line_s) begin
                        emit_bit = 1'b1;
                        st_d     = ST_IDLE;
                    end else begin
                        st_d = ST_RISE;
                    end
                end
            end
            ST_RISE: begin
                if (line_s) begin
                    if (t_cnt > STD_RST_C) begin
                        rst_std = 1'b1;
                        st_d    = ST_PRES;
                        t_load  = 1'b1;
                        t_val   = ONE_C;
                    end else if (od && (t_cnt > OD_RST_C)) begin
                        st_d   = ST_PRES;
                        t_load = 1'b1;
                        t_val  = ONE_C;
                    end else begin
                        st_d = ST_IDLE;
                    end
                end
            end
            ST_PRES: begin
                if (t_cnt == pres_c) begin
                    take_pres = 1'b1;
                    st_d      = ST_RECOV;
                end
            end
            ST_RECOV: begin
                if (t_cnt == recov_c) begin
                    if (line_s) begin
                        emit_rst = 1'b1;
                        st_d     = ST_IDLE;
                    end else begin
                        st_d   = ST_RISE;
                        t_load = 1'b1;
                        t_val  = LONG_MARK;
                    end
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // Outputs and sample latches
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_q        <= 1'b0;
            pres_q       <= 1'b0;
            ev_valid_o   <= 1'b0;
            ev_kind_o    <= EV_BIT;
            ev_bit_o     <= 1'b0;
            ev_present_o <= 1'b0;
            ev_od_o      <= 1'b0;
        end else begin
            if (take_sample) bit_q  <= line_s;
            if (take_pres)   pres_q <= !line_s;
            ev_valid_o   <= emit_bit | emit_rst;
            ev_kind_o    <= emit_rst ? EV_RESET : EV_BIT;
            ev_bit_o     <= emit_bit & bit_q;
            ev_present_o <= emit_rst & pres_q;
            ev_od_o      <= od;
        end
    end

    AST_EVENT_AFTER_DECISION: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid_o |-> ($past(st_q) == ST_SLOT || $past(st_q) == ST_RECOV)); // R3
    AST_EVENT_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid_o |-> $past(line_s)); // R8
    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid_o |=> !ev_valid_o); // R10
    AST_STD_RESET_OD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        rst_std |=> !od); // R5
    AST_SHORT_LOW_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RISE && line_s && !od && t_cnt <= STD_RST_C) |=> (st_q == ST_IDLE)); // R4
endmodule

// File: tb/single_wire_monitor_bench.sv
module single_wire_monitor_bench;

    typedef struct {
        bit    kind;
        bit    b;
        bit    pres;
        bit    od;
        string req;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic line = 1'b1;
    logic ev_valid, ev_kind, ev_bit, ev_present, ev_od;

    exp_t q[$];
    int   n_checks = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    // bench model of the command tracker
    bit        m_od = 1'b0;
    int        m_cnt = 0;
    bit [7:0]  m_cmd = 8'h00;

    always #4 clk = ~clk;

    single_wire_monitor u_single_wire_monitor (
        .clk          (clk),
        .rst_n        (rst_n),
        .line_i       (line),
        .ev_valid_o   (ev_valid),
        .ev_kind_o    (ev_kind),
        .ev_bit_o     (ev_bit),
        .ev_present_o (ev_present),
        .ev_od_o      (ev_od)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    // monitor: pops the scoreboard on every event
    bit prev_valid = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_valid) check(!ev_valid, "R10", "pulse width", ev_valid, 0);
            if (ev_valid) begin
                if (q.size() == 0) begin
                    check(1'b0, "R4", "unexpected event kind", ev_kind, -1);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check(ev_kind == e.kind, e.req, "kind", ev_kind, e.kind);
                    check(ev_bit == e.b, e.req, "bit", ev_bit, e.b);
                    check(ev_present == e.pres, e.req, "presence", ev_present, e.pres);
                    check(ev_od == e.od, e.req, "overdrive", ev_od, e.od);
                end
            end
        end
        prev_valid = ev_valid;
    end

    task automatic pulse(input int lo, input int hi);
        line = 1'b0;
        repeat (lo) @(negedge clk);
        line = 1'b1;
        repeat (hi) @(negedge clk);
    endtask

    task automatic send_bit(input bit b, input string req);
        exp_t e;
        e.kind = 1'b0; e.b = b; e.pres = 1'b0; e.od = m_od; e.req = req;
        q.push_back(e);
        if (m_od) begin
            if (b) pulse(1, 12); else pulse(5, 10);
        end else begin
            if (b) pulse(6, 64); else pulse(40, 30);
        end
        if (m_cnt < 8) begin
            m_cmd[m_cnt] = b;
            m_cnt++;
            if (m_cnt == 8 && (m_cmd == 8'h3C || m_cmd == 8'h69)) m_od = 1'b1;
        end
    endtask

    task automatic send_byte(input bit [7:0] v, input string req);
        for (int i = 0; i < 8; i++) send_bit(v[i], req);
    endtask

    task automatic std_reset(input bit present, input string req);
        exp_t e;
        e.kind = 1'b1; e.b = 1'b0; e.pres = present; e.od = 1'b0; e.req = req;
        q.push_back(e);
        m_od = 1'b0; m_cnt = 0; m_cmd = 8'h00;
        line = 1'b0;
        repeat (500) @(negedge clk);
        line = 1'b1;
        if (present) begin
            repeat (20) @(negedge clk);
            pulse(100, 380);
        end else begin
            repeat (500) @(negedge clk);
        end
    endtask

    task automatic od_reset(input bit present, input string req);
        exp_t e;
        e.kind = 1'b1; e.b = 1'b0; e.pres = present; e.od = 1'b1; e.req = req;
        q.push_back(e);
        line = 1'b0;
        repeat (60) @(negedge clk);
        line = 1'b1;
        if (present) begin
            repeat (3) @(negedge clk);
            pulse(15, 60);
        end else begin
            repeat (80) @(negedge clk);
        end
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            check(1'b0, "R1", "watchdog expired", 0, 1);
            summary();
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        // R1: quiet after reset
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (i == 19) check(!ev_valid && !ev_od, "R1", "idle after reset", ev_valid, 0);
        end

        // R5 R7 R8: standard reset with a device answering
        std_reset(1'b1, "R7");
        // R2 R3 R9: non-matching byte keeps standard speed
        send_byte(8'h55, "R9");
        send_bit(1'b1, "R3");
        // R4: long data low at standard speed, no event
        pulse(200, 40);
        send_bit(1'b0, "R2");
        // R7: reset with no device
        std_reset(1'b0, "R7");
        // R9: overdrive-skip code switches speed
        send_byte(8'h3C, "R9");
        send_byte(8'hA5, "R2");
        // R4: long low below overdrive threshold, no event
        pulse(30, 20);
        send_bit(1'b1, "R4");
        // R6: overdrive reset keeps overdrive
        od_reset(1'b1, "R6");
        send_bit(1'b0, "R6");
        od_reset(1'b0, "R6");
        // R5: standard reset leaves overdrive
        std_reset(1'b1, "R5");
        send_bit(1'b1, "R5");
        // R9: overdrive-match code, from a fresh reset
        std_reset(1'b0, "R9");
        send_byte(8'h69, "R9");
        send_bit(1'b0, "R9");
        // R8: line held low across recovery count, treated as another reset
        begin
            exp_t e;
            e.kind = 1'b1; e.b = 1'b0; e.pres = 1'b0; e.od = 1'b0; e.req = "R8";
            q.push_back(e);
            m_od = 1'b0; m_cnt = 0; m_cmd = 8'h00;
            line = 1'b0;
            repeat (500) @(negedge clk);
            line = 1'b1;
            repeat (20) @(negedge clk);
            pulse(450, 500);
        end
        send_bit(1'b1, "R8");

        repeat (20) @(negedge clk);
        check(q.size() == 0, "R3", "missing events", q.size(), 0);
        done = 1'b1;
        summary();
        $finish;
    end
endmodule